// File: doc/BRIEF.md
# Shared-Adder Arithmetic-Logic Unit

This block is an 8-bit arithmetic-logic unit in which every operation goes through one binary adder. A per-bit operand shaper sits in front of that adder. It rewrites the two operands and produces the adder's carry-in so that the adder's sum is the result of the operation picked by a 3-bit select. For logic operations the shaper forms the bitwise result on the first adder input. It then drives the second input and the carry-in to zero, so the adder passes that value through unchanged.

The sum, the adder's carry out of the top bit and a signed overflow flag are combinational functions of the operands and the select. A load-enabled result register captures the sum on a clock edge, which completes a small calculator datapath. A synchronous active-high reset clears the register.

Top module: `alx_top`

## Requirements
- R1: Select code 000 gives sum = (op_a + op_b) mod 256.
- R2: Select code 001 gives sum = (op_a - op_b) mod 256, formed as op_a plus the inverted op_b plus a carry-in of 1.
- R3: Select code 010 gives sum = (op_a + 1) mod 256, and op_b has no effect.
- R4: Select code 011 gives sum = op_a, and op_b has no effect.
- R5: Select code 100 gives sum = op_a AND op_b, bit by bit.
- R6: Select code 101 gives sum = op_a OR op_b, bit by bit.
- R7: Select code 110 gives sum = op_a XOR op_b, bit by bit.
- R8: Select code 111 gives sum = NOT op_a, and op_b has no effect.
- R9: For select codes 000, 001 and 010, ovf equals the carry into bit 7 XOR the carry out of bit 7. This is 1 exactly when the signed two's-complement result is out of range. It is never 1 when the two adder inputs differ in sign bit.
- R10: For select codes 011 to 111, ovf is 0.
- R11: cout is the adder's raw carry out of bit 7 for every select. It is 1 for add when op_a + op_b > 255, for subtract when op_a >= op_b, and for increment when op_a = 255. It is 0 for codes 011 to 111.
- R12: On a rising clock edge with ld = 1 and rst = 0, acc takes the value of sum present before that edge.
- R13: On a rising clock edge with ld = 0 and rst = 0, acc keeps its value.
- R14: On a rising clock edge with rst = 1, acc becomes 0, whatever the value of ld.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the result register |
| ld | input | 1 | Load enable for the result register |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| sel | input | 3 | Operation select |
| sum | output | 8 | Combinational adder result |
| cout | output | 1 | Carry out of bit 7 |
| ovf | output | 1 | Signed overflow flag |
| acc | output | 8 | Result register |

## Verification
The only state in the block is the result register. If it held a wrong value, acc would show that value from the clock edge after the bad load, and it would keep showing it until the next load or reset. Faults in the operand shaper or in the carry chain have no state to hide in. They show on sum, cout or ovf within the same cycle, for any operand pair that uses the faulty bit. For that reason every select is swept over all 65,536 operand pairs, and each sum, carry and overflow is compared with values computed arithmetically.

// File: rtl/alx_pkg.sv
package alx_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_INC  = 3'b010,
    OP_PASS = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_NOTA = 3'b111
  } alx_op_e;

  function automatic logic op_is_arith(input alx_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
  endfunction
endpackage

// File: rtl/alx_ext_bit.sv
module alx_ext_bit
  import alx_pkg::*;
(
  input  alx_op_e op,
  input  logic    a,
  input  logic    b,
  output logic    ia,
  output logic    ib
);
  always_comb begin
    ia = a;
    ib = 1'b0;
    unique case (op)
      OP_ADD:  ib = b;
      OP_SUB:  ib = ~b;
      OP_INC:  ib = 1'b0;
      OP_PASS: ib = 1'b0;
      OP_AND:  ia = a & b;
      OP_OR:   ia = a | b;
      OP_XOR:  ia = a ^ b;
      OP_NOTA: ia = ~a;
      default: ia = a;
    endcase
  end
endmodule

// File: rtl/alx_extender.sv
module alx_extender
  import alx_pkg::*;
#(
  parameter int W = 8
) (
  input  alx_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   ia,
  output logic [W-1:0]   ib,
  output logic           cin
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    alx_ext_bit u_bit (
      .op (op),
      .a  (a[i]),
      .b  (b[i]),
      .ia (ia[i]),
      .ib (ib[i])
    );
  end

  assign cin = (op == OP_SUB) || (op == OP_INC);
endmodule

// File: rtl/alx_adder.sv
module alx_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] ia,
  input  logic [W-1:0] ib,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         c_msb,
  output logic         c_out
);
  localparam int LW = W - 1;

  logic [LW:0] low_ext;

  assign low_ext = {1'b0, ia[LW-1:0]} + {1'b0, ib[LW-1:0]} + {{LW{1'b0}}, cin};
  assign c_msb   = low_ext[LW];
  assign s       = {ia[LW] ^ ib[LW] ^ c_msb, low_ext[LW-1:0]};
  assign c_out   = (ia[LW] & ib[LW]) | (ia[LW] & c_msb) | (ib[LW] & c_msb);
endmodule

// File: rtl/alx_top.sv
module alx_top
  import alx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   sel,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf,
  output logic [W-1:0] acc
);
  localparam int MSB = W - 1;

  alx_op_e      op;
  logic [W-1:0] ia, ib;
  logic         cin, c_msb, c_out;

  assign op = alx_op_e'(sel);

  alx_extender #(.W(W)) u_ext (
    .op  (op),
    .a   (op_a),
    .b   (op_b),
    .ia  (ia),
    .ib  (ib),
    .cin (cin)
  );

  alx_adder #(.W(W)) u_add (
    .ia    (ia),
    .ib    (ib),
    .cin   (cin),
    .s     (sum),
    .c_msb (c_msb),
    .c_out (c_out)
  );

  assign cout = c_out;
  assign ovf  = op_is_arith(op) ? (c_msb ^ c_out) : 1'b0;

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (ld) acc <= sum;
  end

  assert_load_R12: assert property (@(posedge clk) disable iff (rst)
    ld |=> acc == $past(sum));

  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(acc));

  assert_logic_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    !op_is_arith(op) |-> !ovf);

  assert_mixed_sign_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (ia[MSB] != ib[MSB]) |-> !ovf);

  assert_logic_zero_carry_R11: assert property (@(posedge clk) disable iff (rst)
    sel[2] |-> !cout);

  assert_logic_quiet_adder_R5: assert property (@(posedge clk) disable iff (rst)
    sel[2] |-> (ib == '0 && !cin));
endmodule

// File: tb/sim_alx_top.sv
`timescale 1ns/1ps
module sim_alx_top;
  localparam real HALF = 4.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [2:0] sel = '0;
  logic [7:0] sum, acc;
  logic       cout, ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(HALF) clk = ~clk;

  alx_top u0 (
    .clk(clk), .rst(rst), .ld(ld), .op_a(op_a), .op_b(op_b), .sel(sel),
    .sum(sum), .cout(cout), .ovf(ovf), .acc(acc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s sel=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tag, sel, op_a, op_b, act, exp);
    end
  endtask

  initial begin
    #(HALF * 2 * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int exp_s, exp_c, exp_v;
    string tag;
    logic [7:0] hold;
    repeat (3) @(posedge clk);
    #1;
    chk("R14 reset acc", acc, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          sel = 3'(s); op_a = 8'(a); op_b = 8'(b);
          #1;
          exp_c = 0; exp_v = 0;
          case (s)
            0: begin tag = "R1";
                 exp_s = (a + b) % 256; exp_c = (a + b > 255);
                 exp_v = (a[7] == b[7]) && (exp_s[7] != a[7]); end
            1: begin tag = "R2";
                 exp_s = (a - b + 256) % 256; exp_c = (a >= b);
                 exp_v = (a[7] != b[7]) && (exp_s[7] != a[7]); end
            2: begin tag = "R3";
                 exp_s = (a + 1) % 256; exp_c = (a == 255); exp_v = (a == 127); end
            3: begin tag = "R4"; exp_s = a; end
            4: begin tag = "R5"; exp_s = a & b; end
            5: begin tag = "R6"; exp_s = a | b; end
            6: begin tag = "R7"; exp_s = a ^ b; end
            default: begin tag = "R8"; exp_s = (~a) & 255; end
          endcase
          chk({tag, " sum"}, sum, exp_s);
          chk("R11 cout", cout, exp_c);
          chk(s < 3 ? "R9 ovf" : "R10 ovf", ovf, exp_v);
        end
      end
    end

    // R12: load captures sum
    @(negedge clk);
    sel = 3'b001; op_a = 8'd5; op_b = 8'd9; ld = 1'b1;
    @(posedge clk); #1;
    chk("R12 load sub", acc, 252);
    @(negedge clk);
    sel = 3'b110; op_a = 8'hF0; op_b = 8'h3C;
    @(posedge clk); #1;
    chk("R12 load xor", acc, 8'hCC);

    // R13: hold while ld low
    @(negedge clk);
    hold = acc; ld = 1'b0; sel = 3'b000; op_a = 8'd1; op_b = 8'd2;
    repeat (3) @(posedge clk);
    #1;
    chk("R13 hold", acc, hold);

    // R14: reset overrides load
    @(negedge clk);
    rst = 1'b1; ld = 1'b1;
    @(posedge clk); #1;
    chk("R14 reset with ld", acc, 0);
    @(negedge clk);
    rst = 1'b0; ld = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule